// File: doc/BRIEF.md
# Four-Slot VLIW Register Datapath

This block executes one very-long instruction word per clock. The word carries four sub-instructions, one for each of four functional units. All four units run in the same cycle against a shared file of sixteen registers. Every unit may read any two of the sixteen registers. Each unit may write only into its own bank of four registers, so no two units can write the same register.

Units 0 and 1 are arithmetic units. Unit 2 loads a constant into its bank. Unit 3 is a bitwise logic unit. A build-time switch can plant a known defect in unit 3, so that XOR returns OR. Checking tools can use this to find out whether they notice the defect.

A debug port shows the whole register file. It also shows a record of the last non-NOP operation that unit 3 carried out, so that a check on the register values can refer back to the instruction that produced them.

Top module: `vliw_datapath`

## Requirements
- R1: After a cycle with `rst_n` low at the clock edge, all sixteen registers read zero and the unit-3 record (opcode, destination, both sources) reads zero.
- R2: All units read register values from before the current edge. A register written in a cycle appears as a source with its old value in that same cycle, and all writes land together at the edge.
- R3: Units 0 and 1, opcode 2'b01 (ADD), write srcA + srcB modulo 2^DW to bank register `dst`. Unit 0 owns R0-R3 and unit 1 owns R4-R7.
- R4: Units 0 and 1, opcode 2'b10 (SUB), write srcA - srcB modulo 2^DW.
- R5: Units 0 and 1, opcode 2'b11 (MUL), write the low DW bits of srcA * srcB.
- R6: Opcode 2'b00 is NOP for every unit and leaves that unit's bank unchanged. On unit 2, the codes 2'b10 and 2'b11 also act as NOP.
- R7: Unit 2, opcode 2'b01 (load), writes its DW-bit immediate into register R8 + `dst`.
- R8: Unit 3 writes into R12 + `dst`: opcode 2'b01 gives AND, 2'b10 gives OR, and 2'b11 gives XOR of its two sources.
- R9: An operation changes only its own unit's bank. The other twelve registers hold their values.
- R10: When unit 3's opcode is not NOP, the record takes that opcode, destination and both source indices at the edge. A unit-3 NOP leaves the record unchanged.
- R11: With `FAULT_XOR` set, unit 3 opcode 2'b11 yields srcA | srcB. Bit positions where both operands are 1 then read 1 instead of 0.

Sub-instruction layout, with the LSB first: op[1:0], dst[3:2], srcA[7:4], srcB[11:8]. Unit 2 uses op[1:0], dst[3:2], imm[DW+3:4]. In the instruction word, unit 0 sits at bit 0, unit 1 at bit 12, unit 2 at bit 24 and unit 3 at bit 28+DW. The word is 40+DW bits wide. Register k is found at `dbg_regs[k*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 40+DW | Four packed sub-instructions |
| dbg_regs | output | 16*DW | All registers, R0 in the low bits |
| u3_last_op | output | 2 | Opcode of the last non-NOP unit-3 operation |
| u3_last_dst | output | 2 | Bank index written by that operation |
| u3_last_src_a | output | 4 | First source register of that operation |
| u3_last_src_b | output | 4 | Second source register of that operation |

## Verification
The bench builds two instances. The main one uses DW=16 with the defect switch off. Operands are chosen so that ADD carries out of the word, SUB borrows, and MUL loses high product bits, which exercises the wrap rules. A second instance uses DW=4 with `FAULT_XOR` set. That instance shows both a narrow word and the XOR-to-OR defect, on operands that share 1 bits.

// File: rtl/vliw_pkg.sv
// Package: shared constants and opcode encodings for the four-slot datapath.
// Assumes exactly four units, each owning a four-register bank.
package vliw_pkg;
    localparam int N_UNITS   = 4;
    localparam int BANK_SZ   = 4;
    localparam int N_REGS    = N_UNITS * BANK_SZ;
    localparam int IDX_W     = $clog2(N_REGS);
    localparam int BSEL_W    = $clog2(BANK_SZ);
    localparam int OPC_W     = 2;
    localparam int SLOT_W    = OPC_W + BSEL_W + 2 * IDX_W;
    localparam int IMM_HDR_W = OPC_W + BSEL_W;

    typedef enum logic [OPC_W-1:0] {
        AR_NOP = 2'b00, AR_ADD = 2'b01, AR_SUB = 2'b10, AR_MUL = 2'b11
    } arith_op_e;

    typedef enum logic [OPC_W-1:0] {
        LG_NOP = 2'b00, LG_AND = 2'b01, LG_OR = 2'b10, LG_XOR = 2'b11
    } logic_op_e;

    localparam logic [OPC_W-1:0] IM_LOAD = 2'b01;

    // Bit offset of a unit's sub-instruction inside the instruction word
    function automatic int slot_off(input int u, input int dw);
        return (u < 3) ? u * SLOT_W : 2 * SLOT_W + IMM_HDR_W + dw + SLOT_W - SLOT_W;
    endfunction
endpackage

// File: rtl/vliw_arith_unit.sv
// Arithmetic unit: ADD, SUB, MUL (low word) and NOP on two DW-bit operands.
// Assumes operands were read from pre-edge register state; result wraps.
module vliw_arith_unit
    import vliw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [BSEL_W-1:0] dst,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    output logic              we,
    output logic [BSEL_W-1:0] wa,
    output logic [DW-1:0]     wd
);
    // Select the result and write enable from the opcode
    always_comb begin
        wa = dst;
        we = 1'b1;
        case (arith_op_e'(op))
            AR_ADD:  wd = a + b;
            AR_SUB:  wd = a - b;
            AR_MUL:  wd = a * b;
            default: begin
                wd = '0;
                we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vliw_imm_unit.sv
// Immediate unit: loads a DW-bit constant into its bank; other codes are NOP.
// Assumes the immediate is taken straight from the instruction word.
module vliw_imm_unit
    import vliw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [BSEL_W-1:0] dst,
    input  logic [DW-1:0]     imm,
    output logic              we,
    output logic [BSEL_W-1:0] wa,
    output logic [DW-1:0]     wd
);
    // Only the load code writes; all other codes leave the bank alone
    always_comb begin
        we = (op == IM_LOAD);
        wa = dst;
        wd = imm;
    end
endmodule

// File: rtl/vliw_logic_unit.sv
// Logic unit: AND, OR, XOR and NOP. With FAULT_XOR set, XOR is computed as OR
// (a planted defect for exercising checkers). Assumes pre-edge operands.
module vliw_logic_unit
    import vliw_pkg::*;
#(
    parameter int DW        = 16,
    parameter bit FAULT_XOR = 1'b0
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [BSEL_W-1:0] dst,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    output logic              we,
    output logic [BSEL_W-1:0] wa,
    output logic [DW-1:0]     wd
);
    logic [DW-1:0] xor_res;

    // Choose between the correct and the defective XOR at build time
    generate
        if (FAULT_XOR) begin : g_flt
            assign xor_res = a | b;
        end else begin : g_ok
            assign xor_res = a ^ b;
        end
    endgenerate

    // Select the bitwise result from the opcode
    always_comb begin
        wa = dst;
        we = 1'b1;
        case (logic_op_e'(op))
            LG_AND:  wd = a & b;
            LG_OR:   wd = a | b;
            LG_XOR:  wd = xor_res;
            default: begin
                wd = '0;
                we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vliw_regfile.sv
// Banked register file: N_REGS words, one write port per unit, each confined
// to that unit's bank. Synchronous active-low clear. Assumes banks are disjoint.
module vliw_regfile
    import vliw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we [N_UNITS],
    input  logic [BSEL_W-1:0] wa [N_UNITS],
    input  logic [DW-1:0]     wd [N_UNITS],
    output logic [DW-1:0]     regs_o [N_REGS]
);
    logic [DW-1:0] rf_q [N_REGS];

    generate
        for (genvar bk = 0; bk < N_UNITS; bk++) begin : g_bank
            for (genvar e = 0; e < BANK_SZ; e++) begin : g_ent
                // Clear on reset, else take this bank's port when addressed
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        rf_q[bk*BANK_SZ+e] <= '0;
                    else if (we[bk] && wa[bk] == BSEL_W'(e))
                        rf_q[bk*BANK_SZ+e] <= wd[bk];
                end

                // A bank with its port idle keeps its value (R6, R9)
                assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    !we[bk] |=> rf_q[bk*BANK_SZ+e] == $past(rf_q[bk*BANK_SZ+e]));

                // The cycle after reset every word is zero
                assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(rst_n) |-> rf_q[bk*BANK_SZ+e] == '0);
            end
        end
    endgenerate

    assign regs_o = rf_q;
endmodule

// File: rtl/vliw_datapath.sv
// Four-slot VLIW datapath top: splits the instruction word, reads operands from
// the register file, runs two arithmetic units, an immediate unit and a logic
// unit in parallel, and records the last non-NOP logic-unit operation.
// Assumes one instruction per cycle and no hazards beyond pre-edge reads.
module vliw_datapath
    import vliw_pkg::*;
#(
    parameter int DW        = 16,
    parameter bit FAULT_XOR = 1'b0,
    localparam int IW       = 3 * SLOT_W + IMM_HDR_W + DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IW-1:0]        instr,
    output logic [N_REGS*DW-1:0] dbg_regs,
    output logic [OPC_W-1:0]     u3_last_op,
    output logic [BSEL_W-1:0]    u3_last_dst,
    output logic [IDX_W-1:0]     u3_last_src_a,
    output logic [IDX_W-1:0]     u3_last_src_b
);
    localparam int OFF2 = 2 * SLOT_W;
    localparam int OFF3 = 2 * SLOT_W + IMM_HDR_W + DW;

    logic [DW-1:0]     regs [N_REGS];
    logic [OPC_W-1:0]  u_op  [N_UNITS];
    logic [BSEL_W-1:0] u_dst [N_UNITS];
    logic [IDX_W-1:0]  u_sa  [N_UNITS];
    logic [IDX_W-1:0]  u_sb  [N_UNITS];
    logic [DW-1:0]     rd_a  [N_UNITS];
    logic [DW-1:0]     rd_b  [N_UNITS];
    logic              u_we  [N_UNITS];
    logic [BSEL_W-1:0] u_wa  [N_UNITS];
    logic [DW-1:0]     u_wd  [N_UNITS];
    logic [DW-1:0]     imm2;

    logic [OPC_W-1:0]  rec_op_q;
    logic [BSEL_W-1:0] rec_dst_q;
    logic [IDX_W-1:0]  rec_sa_q, rec_sb_q;

    assign imm2 = instr[OFF2+IMM_HDR_W +: DW];

    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            localparam int OFF = (u == 3) ? OFF3 : u * SLOT_W;

            // Field decode and operand read for this slot
            assign u_op[u]  = instr[OFF +: OPC_W];
            assign u_dst[u] = instr[OFF+OPC_W +: BSEL_W];
            if (u != 2) begin : g_rd
                assign u_sa[u] = instr[OFF+IMM_HDR_W +: IDX_W];
                assign u_sb[u] = instr[OFF+IMM_HDR_W+IDX_W +: IDX_W];
            end else begin : g_nord
                assign u_sa[u] = '0;
                assign u_sb[u] = '0;
            end
            assign rd_a[u] = regs[u_sa[u]];
            assign rd_b[u] = regs[u_sb[u]];

            if (u < 2) begin : g_ar
                vliw_arith_unit #(.DW(DW)) u_alu (
                    .op(u_op[u]), .dst(u_dst[u]), .a(rd_a[u]), .b(rd_b[u]),
                    .we(u_we[u]), .wa(u_wa[u]), .wd(u_wd[u]));
            end else if (u == 2) begin : g_im
                vliw_imm_unit #(.DW(DW)) u_imm (
                    .op(u_op[u]), .dst(u_dst[u]), .imm(imm2),
                    .we(u_we[u]), .wa(u_wa[u]), .wd(u_wd[u]));
            end else begin : g_lg
                vliw_logic_unit #(.DW(DW), .FAULT_XOR(FAULT_XOR)) u_lgu (
                    .op(u_op[u]), .dst(u_dst[u]), .a(rd_a[u]), .b(rd_b[u]),
                    .we(u_we[u]), .wa(u_wa[u]), .wd(u_wd[u]));
            end
        end

        for (genvar k = 0; k < N_REGS; k++) begin : g_dbg
            assign dbg_regs[k*DW +: DW] = regs[k];
        end
    endgenerate

    vliw_regfile #(.DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(u_we), .wa(u_wa), .wd(u_wd), .regs_o(regs));

    // Keep the last non-NOP logic-unit operation for later checking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_op_q  <= '0;
            rec_dst_q <= '0;
            rec_sa_q  <= '0;
            rec_sb_q  <= '0;
        end else if (u_op[3] != LG_NOP) begin
            rec_op_q  <= u_op[3];
            rec_dst_q <= u_dst[3];
            rec_sa_q  <= u_sa[3];
            rec_sb_q  <= u_sb[3];
        end
    end

    assign u3_last_op    = rec_op_q;
    assign u3_last_dst   = rec_dst_q;
    assign u3_last_src_a = rec_sa_q;
    assign u3_last_src_b = rec_sb_q;

    // Unit 0 ADD lands the wrapped sum of pre-edge operands
    assert_add_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        u_op[0] == AR_ADD |=> regs[{2'd0, $past(u_dst[0])}] == $past(rd_a[0] + rd_b[0]));

    // Unit 1 SUB lands the wrapped difference
    assert_sub_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        u_op[1] == AR_SUB |=> regs[{2'd1, $past(u_dst[1])}] == $past(rd_a[1] - rd_b[1]));

    // Unit 0 MUL keeps the low word of the product
    assert_mul_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        u_op[0] == AR_MUL |=> regs[{2'd0, $past(u_dst[0])}] == $past(rd_a[0] * rd_b[0]));

    // Unit 2 load writes the immediate
    assert_load_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        u_op[2] == IM_LOAD |=> regs[{2'd2, $past(u_dst[2])}] == $past(imm2));

    // Unit 3 XOR result, correct or defective by build switch
    assert_xor_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (u_op[3] == LG_XOR && !FAULT_XOR) |=>
            regs[{2'd3, $past(u_dst[3])}] == $past(rd_a[3] ^ rd_b[3]));
    assert_xor_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (u_op[3] == LG_XOR && FAULT_XOR) |=>
            regs[{2'd3, $past(u_dst[3])}] == $past(rd_a[3] | rd_b[3]));

    // A unit-3 NOP leaves the record untouched
    assert_rec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        u_op[3] == LG_NOP |=> $stable({u3_last_op, u3_last_dst, u3_last_src_a, u3_last_src_b}));
endmodule

// File: tb/tb_vliw_datapath.sv
// Directed bench: main instance DW=16 (no defect), second instance DW=4 with XOR defect.
module tb_vliw_datapath;
    localparam int DW  = 16;
    localparam int DWF = 4;
    localparam int IW  = 40 + DW;
    localparam int IWF = 40 + DWF;

    logic clk = 1'b0;
    logic rst_n;
    logic [IW-1:0]   instr;
    logic [IWF-1:0]  instr_f;
    logic [16*DW-1:0]  regs_m;
    logic [16*DWF-1:0] regs_f;
    logic [1:0] lop, ldst, lop_f, ldst_f;
    logic [3:0] lsa, lsb, lsa_f, lsb_f;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] expv [16];

    always #4 clk = ~clk;

    vliw_datapath #(.DW(DW), .FAULT_XOR(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .dbg_regs(regs_m),
        .u3_last_op(lop), .u3_last_dst(ldst), .u3_last_src_a(lsa), .u3_last_src_b(lsb));

    vliw_datapath #(.DW(DWF), .FAULT_XOR(1'b1)) dut_flt (
        .clk(clk), .rst_n(rst_n), .instr(instr_f), .dbg_regs(regs_f),
        .u3_last_op(lop_f), .u3_last_dst(ldst_f), .u3_last_src_a(lsa_f), .u3_last_src_b(lsb_f));

    function automatic logic [11:0] slot(input logic [1:0] op, input logic [1:0] d,
                                         input logic [3:0] a, input logic [3:0] b);
        return {b, a, d, op};
    endfunction

    function automatic logic [IW-1:0] word(input logic [11:0] s0, input logic [11:0] s1,
                                           input logic [1:0] op2, input logic [1:0] d2,
                                           input logic [DW-1:0] imm, input logic [11:0] s3);
        return {s3, imm, d2, op2, s1, s0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare all sixteen registers with the bench model
    task automatic chk_all(input string req);
        for (int k = 0; k < 16; k++)
            chk(req, 64'(regs_m[k*DW +: DW]), 64'(expv[k]));
    endtask

    task automatic step(input logic [IW-1:0] w, input logic [IWF-1:0] wf);
        instr   = w;
        instr_f = wf;
        @(negedge clk);
        instr   = '0;
        instr_f = '0;
    endtask

    task automatic t_reset;
        for (int k = 0; k < 16; k++) expv[k] = '0;
        chk_all("R1");
        chk("R1", 64'({lop, ldst, lsa, lsb}), 64'd0);
    endtask

    task automatic t_load;
        step(word(12'd0, 12'd0, 2'b01, 2'd0, 16'hF00F, 12'd0), '0);
        step(word(12'd0, 12'd0, 2'b01, 2'd1, 16'hFF00, 12'd0), '0);
        step(word(12'd0, 12'd0, 2'b01, 2'd2, 16'h0300, 12'd0), '0);
        step(word(12'd0, 12'd0, 2'b01, 2'd3, 16'h0111, 12'd0), '0);
        // codes 2'b10/2'b11 on unit 2 are NOP
        step(word(12'd0, 12'd0, 2'b11, 2'd0, 16'hAAAA, 12'd0), '0);
        expv[8] = 16'hF00F; expv[9] = 16'hFF00; expv[10] = 16'h0300; expv[11] = 16'h0111;
        chk_all("R7 R6 R9");
    endtask

    task automatic t_arith;
        // unit0 ADD R0=R8+R9 (carry out), unit1 SUB R5=R8-R9 (borrow)
        step(word(slot(2'b01, 2'd0, 4'd8, 4'd9), slot(2'b10, 2'd1, 4'd8, 4'd9),
                  2'b00, 2'd0, '0, 12'd0), '0);
        expv[0] = 16'hEF0F; expv[5] = 16'hF10F;
        chk("R3", 64'(regs_m[0*DW +: DW]), 64'(16'hEF0F));
        chk("R4", 64'(regs_m[5*DW +: DW]), 64'(16'hF10F));
        // unit0 MUL R1=R10*R11, unit1 ADD R7=R0+R5 (cross-bank source)
        step(word(slot(2'b11, 2'd1, 4'd10, 4'd11), slot(2'b01, 2'd3, 4'd0, 4'd5),
                  2'b00, 2'd0, '0, 12'd0), '0);
        expv[1] = 16'h3300; expv[7] = 16'hE01E;
        chk("R5", 64'(regs_m[1*DW +: DW]), 64'(16'h3300));
        chk_all("R9 R3");
    endtask

    task automatic t_same_cycle;
        // unit2 rewrites R8 while unit0 reads it: old value used
        step(word(slot(2'b01, 2'd2, 4'd8, 4'd8), 12'd0, 2'b01, 2'd0, 16'h0001, 12'd0), '0);
        expv[2] = 16'hE01E; expv[8] = 16'h0001;
        chk("R2", 64'(regs_m[2*DW +: DW]), 64'(16'hE01E));
        chk_all("R2");
    endtask

    task automatic t_logic;
        step(word(12'd0, 12'd0, 2'b00, 2'd0, '0, slot(2'b01, 2'd0, 4'd9, 4'd10)), '0);
        expv[12] = 16'h0300;
        chk("R10", 64'({lop, ldst, lsa, lsb}), 64'({2'b01, 2'd0, 4'd9, 4'd10}));
        step(word(12'd0, 12'd0, 2'b00, 2'd0, '0, slot(2'b10, 2'd1, 4'd9, 4'd11)), '0);
        expv[13] = 16'hFF11;
        step(word(12'd0, 12'd0, 2'b00, 2'd0, '0, slot(2'b11, 2'd2, 4'd9, 4'd11)), '0);
        expv[14] = 16'hFE11;
        chk("R8", 64'(regs_m[14*DW +: DW]), 64'(16'hFE11));
        chk("R10", 64'({lop, ldst, lsa, lsb}), 64'({2'b11, 2'd2, 4'd9, 4'd11}));
        chk_all("R8");
    endtask

    task automatic t_nop;
        // all-NOP word, but with source fields set: nothing changes
        step(word(slot(2'b00, 2'd3, 4'd1, 4'd2), slot(2'b00, 2'd0, 4'd3, 4'd4),
                  2'b00, 2'd3, 16'h5555, slot(2'b00, 2'd3, 4'd5, 4'd6)), '0);
        chk_all("R6");
        chk("R10", 64'({lop, ldst, lsa, lsb}), 64'({2'b11, 2'd2, 4'd9, 4'd11}));
    endtask

    task automatic t_fault;
        logic [IWF-1:0] wf;
        wf = '0; wf[27:24] = {4'hC}; wf[25:24] = 2'b00;
        wf = {12'd0, 4'hC, 2'd0, 2'b01, 24'd0};
        step('0, wf);
        wf = {12'd0, 4'hA, 2'd1, 2'b01, 24'd0};
        step('0, wf);
        wf = {slot(2'b11, 2'd0, 4'd8, 4'd9), 4'h0, 2'd0, 2'b00, 24'd0};
        step('0, wf);
        chk("R11", 64'(regs_f[12*DWF +: DWF]), 64'(4'hE));
        chk("R11", 64'(regs_f[8*DWF +: DWF]), 64'(4'hC));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        instr = '0;
        instr_f = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_arith();
        t_same_cycle();
        t_logic();
        t_nop();
        t_fault();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule